// File: doc/BRIEF.md
# Sidetone Multi-Band Equalizer

This block shapes a sidetone signal before it is mixed back into a playback path. A selector picks one of five sample sources (two capture decimators and three playback streams) or a forced zero. The chosen sample is scaled by a signed input gain in decibels. It then runs through a cascade of five second-order IIR bands, and the result is handed to the playback mixers. Each band can be switched in or out on its own. A bypassed band passes its input through unchanged, and the total latency is the same in either case.

The cascade is computed by one shared arithmetic unit that visits the bands in order, one band per clock. For the band it is working on, it drives a band index to an external coefficient store and reads back that band's five coefficients combinationally in the same cycle. The equalizer is meant to be placed twice in a chip. Each copy has its own source selection, gain, enables and coefficient store.

Top module: `sideq_top`

## Requirements
- R1: `src_sel` picks the equalizer input as follows: 1 = `dec1_in`, 2 = `dec2_in`, 3 = `rx1_in`, 4 = `rx2_in`, 5 = `rx3_in`. Code 0 and the unused codes 6 and 7 feed a zero sample.
- R2: The gain `gain_db` is a signed dB value. It is clamped to the range -84..+40, and n = gain+84. The scaled sample is floor(x · M[n mod 6] · 2^(n div 6) / 2^29), where M = {32768, 36766, 41252, 46286, 51934, 58271}. A gain of 0 is exactly unity.
- R3: An enabled band computes y = (b0·x + b1·x1 + b2·x2 − a1·y1 − a2·y2) >>> 28 in direct form I. The coefficients are 30-bit two's complement values with 28 fraction bits. `coef_word` packs them with b0 in bits 29:0, then b1, b2, a1, and a2 in bits 149:120. The word returned for `coef_band` = k belongs to band k+1.
- R4: Bit k of `band_en` enables band k+1. Bands run in the order 1 to 5. A disabled band forwards its input unchanged and leaves its history untouched.
- R5: The gain output and every band output saturate to the 24-bit signed range [-8388608, 8388607].
- R6: `out_valid` pulses high for exactly one cycle, 5 clock edges after the edge that accepted the sample. The latency does not depend on `band_en`.
- R7: A sample is accepted on `in_valid` only when the block is idle. An `in_valid` that arrives during the 6 edges from acceptance up to and including the result edge is ignored.
- R8: When bit k of `band_en` rises from 0 to 1, the history of band k+1 (x1, x2, y1, y2) is cleared.
- R9: A synchronous reset clears `out_valid`, `out_data` and all band histories.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| src_sel | input | 3 | Source select code |
| gain_db | input | 8 | Signed input gain in dB |
| dec1_in | input | 24 | Decimator 1 sample |
| dec2_in | input | 24 | Decimator 2 sample |
| rx1_in | input | 24 | Playback stream 1 sample |
| rx2_in | input | 24 | Playback stream 2 sample |
| rx3_in | input | 24 | Playback stream 3 sample |
| band_en | input | 5 | Per-band enable, bit k = band k+1 |
| coef_band | output | 3 | Band index for the coefficient store |
| coef_word | input | 150 | Five coefficients of the addressed band |
| out_valid | output | 1 | Result strobe |
| out_data | output | 24 | Equalized sample |

## Verification
A behavioural model in the bench tracks the filter histories and expected strobes and is compared with the outputs on every clock. The bench covers all eight selector codes, so a design that sends codes 6 or 7 to a real source produces a nonzero sample. It covers the gain ends and the values clamped beyond them, where a wrong exponent split or a missing clamp gives a scaled or wrapped value. It drives coefficients large enough to overflow each band, so a design that wraps instead of saturating shows a sign flip. It sends strobes while the block is busy, which a design that accepts them turns into an early or altered result. It also toggles band enables so that a design that keeps old history on re-enable, or changes history in a bypassed band, produces a different impulse response.

// File: rtl/sideq_pkg.sv
package sideq_pkg;
    localparam int SAMPLE_W       = 24;
    localparam int COEF_W         = 30;
    localparam int COEF_FRAC      = 28;
    localparam int NUM_BANDS      = 5;
    localparam int COEFS_PER_BAND = 5;
    localparam int BAND_COEF_W    = COEF_W * COEFS_PER_BAND;
    localparam int BAND_IDX_W     = $clog2(NUM_BANDS);
    localparam int SEL_W          = 3;
    localparam int GAIN_W         = 8;
    localparam int GAIN_MIN       = -84;
    localparam int GAIN_MAX       = 40;
    localparam int DB_PER_OCTAVE  = 6;
    localparam int MANT_FRAC      = 15;
    localparam int MANT_W         = MANT_FRAC + 2;
    localparam int UNITY_OCTAVE   = (0 - GAIN_MIN) / DB_PER_OCTAVE;
    localparam int ACC_W          = 64;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0]   coef_t;
    typedef logic signed [ACC_W-1:0]    acc_t;

    // b0 sits in the least significant slot of the store word
    typedef struct packed {
        coef_t a2;
        coef_t a1;
        coef_t b2;
        coef_t b1;
        coef_t b0;
    } band_coef_t;

    typedef struct packed {
        sample_t y2;
        sample_t y1;
        sample_t x2;
        sample_t x1;
    } band_hist_t;

    typedef enum logic [SEL_W-1:0] {
        SRC_ZERO = 3'd0,
        SRC_DEC1 = 3'd1,
        SRC_DEC2 = 3'd2,
        SRC_RX1  = 3'd3,
        SRC_RX2  = 3'd4,
        SRC_RX3  = 3'd5
    } src_sel_e;

    function automatic sample_t clip(input acc_t v);
        acc_t hi;
        acc_t lo;
        hi = (acc_t'(1) <<< (SAMPLE_W - 1)) - acc_t'(1);
        lo = -hi - acc_t'(1);
        if (v > hi)      return sample_t'(hi);
        else if (v < lo) return sample_t'(lo);
        else             return sample_t'(v);
    endfunction

    // 10^(r/20) for r = 0..5 dB, unsigned with MANT_FRAC fraction bits
    function automatic logic [MANT_W-1:0] step_mantissa(input int r);
        case (r)
            1:       return MANT_W'(36766);
            2:       return MANT_W'(41252);
            3:       return MANT_W'(46286);
            4:       return MANT_W'(51934);
            5:       return MANT_W'(58271);
            default: return MANT_W'(32768);
        endcase
    endfunction
endpackage

// File: rtl/sideq_src_gain.sv
module sideq_src_gain
    import sideq_pkg::*;
(
    input  logic [SEL_W-1:0]         sel,
    input  logic signed [GAIN_W-1:0] gain_db,
    input  sample_t                  dec1,
    input  sample_t                  dec2,
    input  sample_t                  rx1,
    input  sample_t                  rx2,
    input  sample_t                  rx3,
    output sample_t                  gained
);
    sample_t picked;
    int      g_db;
    int      steps;
    int      octave;
    int      frac_db;
    acc_t    mant_s;
    acc_t    prod;
    acc_t    scaled;

    always_comb begin
        case (src_sel_e'(sel))
            SRC_DEC1: picked = dec1;
            SRC_DEC2: picked = dec2;
            SRC_RX1:  picked = rx1;
            SRC_RX2:  picked = rx2;
            SRC_RX3:  picked = rx3;
            default:  picked = '0;
        endcase
    end

    always_comb begin
        g_db = int'(gain_db);
        if (g_db < GAIN_MIN) g_db = GAIN_MIN;
        if (g_db > GAIN_MAX) g_db = GAIN_MAX;
        steps   = g_db - GAIN_MIN;
        octave  = steps / DB_PER_OCTAVE;
        frac_db = steps % DB_PER_OCTAVE;
        mant_s  = $signed(ACC_W'(step_mantissa(frac_db)));
        prod    = acc_t'(picked) * mant_s;
        scaled  = (prod <<< octave) >>> (MANT_FRAC + UNITY_OCTAVE);
        gained  = clip(scaled);
    end
endmodule

// File: rtl/sideq_band_bank.sv
module sideq_band_bank
    import sideq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_BANDS-1:0]  band_en,
    input  logic                  step,
    input  logic [BAND_IDX_W-1:0] idx,
    input  sample_t               x_in,
    input  band_coef_t            coef,
    output sample_t               y_out
);
    band_hist_t           hist [NUM_BANDS];
    logic [NUM_BANDS-1:0] en_q;
    band_hist_t           h;
    acc_t                 acc;
    sample_t              filt;

    always_comb begin
        h    = hist[idx];
        acc  = acc_t'(coef.b0) * acc_t'(x_in)
             + acc_t'(coef.b1) * acc_t'(h.x1)
             + acc_t'(coef.b2) * acc_t'(h.x2)
             - acc_t'(coef.a1) * acc_t'(h.y1)
             - acc_t'(coef.a2) * acc_t'(h.y2);
        filt  = clip(acc >>> COEF_FRAC);
        y_out = band_en[idx] ? filt : x_in;
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= band_en;
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NUM_BANDS; k++) begin
            if (rst) begin
                hist[k] <= '0;
            end else if (band_en[k] && !en_q[k]) begin
                hist[k] <= '0;
            end else if (step && (idx == BAND_IDX_W'(k)) && band_en[k]) begin
                hist[k] <= '{y2: hist[k].y1, y1: filt, x2: hist[k].x1, x1: x_in};
            end
        end
    end

    for (genvar k = 0; k < NUM_BANDS; k++) begin : g_band_chk
        // R8
        hist_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (band_en[k] && !en_q[k]) |=> (hist[k] == '0));
        // R4
        bypass_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (step && (idx == BAND_IDX_W'(k)) && !band_en[k]) |=> (hist[k] == $past(hist[k])));
    end
endmodule

// File: rtl/sideq_top.sv
module sideq_top
    import sideq_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [SEL_W-1:0]            src_sel,
    input  logic signed [GAIN_W-1:0]    gain_db,
    input  logic signed [SAMPLE_W-1:0]  dec1_in,
    input  logic signed [SAMPLE_W-1:0]  dec2_in,
    input  logic signed [SAMPLE_W-1:0]  rx1_in,
    input  logic signed [SAMPLE_W-1:0]  rx2_in,
    input  logic signed [SAMPLE_W-1:0]  rx3_in,
    input  logic [NUM_BANDS-1:0]        band_en,
    output logic [BAND_IDX_W-1:0]       coef_band,
    input  logic [BAND_COEF_W-1:0]      coef_word,
    output logic                        out_valid,
    output logic signed [SAMPLE_W-1:0]  out_data
);
    localparam logic [BAND_IDX_W-1:0] LAST_BAND = BAND_IDX_W'(NUM_BANDS - 1);

    logic                  busy;
    logic [BAND_IDX_W-1:0] idx;
    sample_t               work;
    sample_t               gained;
    sample_t               band_y;

    sideq_src_gain u_src (
        .sel     (src_sel),
        .gain_db (gain_db),
        .dec1    (dec1_in),
        .dec2    (dec2_in),
        .rx1     (rx1_in),
        .rx2     (rx2_in),
        .rx3     (rx3_in),
        .gained  (gained)
    );

    sideq_band_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .band_en (band_en),
        .step    (busy),
        .idx     (idx),
        .x_in    (work),
        .coef    (band_coef_t'(coef_word)),
        .y_out   (band_y)
    );

    assign coef_band = idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            idx       <= '0;
            work      <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (!busy) begin
                if (in_valid) begin
                    work <= gained;
                    idx  <= '0;
                    busy <= 1'b1;
                end
            end else begin
                work <= band_y;
                if (idx == LAST_BAND) begin
                    busy      <= 1'b0;
                    idx       <= '0;
                    out_valid <= 1'b1;
                    out_data  <= band_y;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // R6
    pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    // R6
    valid_after_chain_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(busy) && ($past(idx) == LAST_BAND)));
    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && (idx != LAST_BAND)) |=> busy);
endmodule

// File: tb/sim_sideq_top.sv
module sim_sideq_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [2:0]   src_sel = '0;
    logic [7:0]   gain_db = '0;
    logic [23:0]  dec1_in = '0, dec2_in = '0, rx1_in = '0, rx2_in = '0, rx3_in = '0;
    logic [4:0]   band_en = '0;
    logic [2:0]   coef_band;
    logic [149:0] coef_word;
    logic         out_valid;
    logic [23:0]  out_data;

    logic [149:0] cstore [5];
    assign coef_word = cstore[coef_band];

    always #5 clk = ~clk;

    sideq_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_sel(src_sel), .gain_db(gain_db),
        .dec1_in(dec1_in), .dec2_in(dec2_in), .rx1_in(rx1_in), .rx2_in(rx2_in), .rx3_in(rx3_in),
        .band_en(band_en), .coef_band(coef_band), .coef_word(coef_word),
        .out_valid(out_valid), .out_data(out_data)
    );

    int     checks = 0;
    int     errors = 0;
    string  tag = "R9";
    bit     finished = 0;
    longint cyc = 0;

    // reference model state
    longint mx1 [5], mx2 [5], my1 [5], my2 [5];
    logic [4:0] men_q = '0;
    longint last_acc = -100;
    longint due = -1;
    longint pend = 0;
    logic   exp_valid = 1'b0;
    longint exp_data = 0;
    int     mt [6] = '{32768, 36766, 41252, 46286, 51934, 58271};

    function automatic longint sat(longint v);
        if (v > 8388607) return 8388607;
        if (v < -8388608) return -8388608;
        return v;
    endfunction

    function automatic longint cf(int band, int j);
        logic [29:0] w;
        w = cstore[band][j*30 +: 30];
        return longint'($signed(w));
    endfunction

    function automatic longint apply_gain(longint x, int g);
        int n;
        if (g < -84) g = -84;
        if (g > 40) g = 40;
        n = g + 84;
        return sat(((x * mt[n % 6]) <<< (n / 6)) >>> 29);
    endfunction

    function automatic logic [149:0] pack(longint b0, longint b1, longint b2, longint a1, longint a2);
        return {30'(a2), 30'(a1), 30'(b2), 30'(b1), 30'(b0)};
    endfunction

    task automatic model_run();
        longint x, acc, y;
        case (src_sel)
            3'd1: x = longint'($signed(dec1_in));
            3'd2: x = longint'($signed(dec2_in));
            3'd3: x = longint'($signed(rx1_in));
            3'd4: x = longint'($signed(rx2_in));
            3'd5: x = longint'($signed(rx3_in));
            default: x = 0;
        endcase
        x = apply_gain(x, int'($signed(gain_db)));
        for (int k = 0; k < 5; k++) begin
            if (band_en[k]) begin
                acc = cf(k,0)*x + cf(k,1)*mx1[k] + cf(k,2)*mx2[k] - cf(k,3)*my1[k] - cf(k,4)*my2[k];
                y = sat(acc >>> 28);
                mx2[k] = mx1[k]; mx1[k] = x;
                my2[k] = my1[k]; my1[k] = y;
                x = y;
            end
        end
        pend = x;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            for (int k = 0; k < 5; k++) begin mx1[k]=0; mx2[k]=0; my1[k]=0; my2[k]=0; end
            men_q = '0; exp_valid = 1'b0; last_acc = -100; due = -1;
        end else begin
            for (int k = 0; k < 5; k++)
                if (band_en[k] && !men_q[k]) begin mx1[k]=0; mx2[k]=0; my1[k]=0; my2[k]=0; end
            men_q = band_en;
            if (in_valid && cyc >= last_acc + 6) begin
                model_run();
                last_acc = cyc;
                due = cyc + 5;
            end
            if (cyc == due) begin exp_valid = 1'b1; exp_data = pend; end
            else exp_valid = 1'b0;
        end
    end

    task automatic chk(bit ok, string t, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", t, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(out_valid === exp_valid, "R6 valid strobe", longint'(out_valid), longint'(exp_valid));
            if (exp_valid)
                chk(longint'($signed(out_data)) == exp_data, tag, longint'($signed(out_data)), exp_data);
        end
    end

    task automatic pulse();
        @(negedge clk) in_valid = 1'b1;
        @(negedge clk) in_valid = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_rx1(longint v);
        @(negedge clk) rx1_in = 24'(v);
        pulse();
    endtask

    function automatic longint rnd(longint span);
        return longint'($urandom_range(0, 32'(2*span))) - span;
    endfunction

    initial begin
        repeat (500000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL R6 watchdog actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 5; k++)
            cstore[k] = pack((1 <<< 27) + k*(1 <<< 24), -(1 <<< 26), (1 <<< 25),
                             -(1 <<< 27) + k*(1 <<< 25), (1 <<< 26));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(out_valid === 1'b0, "R9 out_valid after reset", longint'(out_valid), 0);
        chk(out_data === 24'd0, "R9 out_data after reset", longint'($signed(out_data)), 0);

        // R1 selector, unity gain, all bands bypassed
        tag = "R1";
        dec1_in = 24'(1000); dec2_in = 24'(-2000); rx1_in = 24'(300000);
        rx2_in = 24'(-4000000); rx3_in = 24'(8000000);
        for (int s = 0; s < 8; s++) begin
            @(negedge clk) src_sel = 3'(s);
            pulse();
        end

        // R2 gain steps and clamping
        tag = "R2";
        src_sel = 3'd3;
        rx1_in = 24'(1000000);
        foreach (mt[i]) begin end
        for (int g = -84; g <= 13; g += 7) begin
            @(negedge clk) gain_db = 8'(g);
            pulse();
        end
        @(negedge clk) gain_db = 8'(-1);   pulse();
        @(negedge clk) gain_db = 8'(-100); pulse();
        @(negedge clk) gain_db = 8'(-128); pulse();

        // R5 gain output saturation, both signs
        tag = "R5";
        @(negedge clk) gain_db = 8'(40);  pulse();
        @(negedge clk) gain_db = 8'(100); rx1_in = 24'(-1000000); pulse();
        @(negedge clk) gain_db = 8'(0);

        // R3 single band impulse and random stream
        tag = "R3";
        @(negedge clk) band_en = 5'b00001;
        send_rx1(1000000);
        for (int i = 0; i < 4; i++) send_rx1(0);
        for (int i = 0; i < 8; i++) send_rx1(rnd(8000000));

        // R4 band subsets and full cascade
        tag = "R4";
        @(negedge clk) band_en = 5'b10100;
        for (int i = 0; i < 6; i++) send_rx1(rnd(4000000));
        @(negedge clk) band_en = 5'b11111;
        for (int i = 0; i < 6; i++) send_rx1(rnd(4000000));

        // R5 band output saturation
        tag = "R5";
        @(negedge clk) begin
            band_en = 5'b00001;
            cstore[0] = pack(510000000, 500000000, 0, 0, 0);
        end
        send_rx1(8000000);
        send_rx1(8000000);
        send_rx1(-8000000);
        send_rx1(-8000000);

        // R8 history cleared on re-enable, held while bypassed
        tag = "R8";
        @(negedge clk) begin
            cstore[0] = pack(1 <<< 27, 1 <<< 26, 1 <<< 25, -(1 <<< 27), 1 <<< 26);
            band_en = 5'b11111;
        end
        send_rx1(3000000);
        send_rx1(-2000000);
        @(negedge clk) band_en = 5'b00000;
        send_rx1(1234567);
        @(negedge clk) band_en = 5'b01010;
        send_rx1(500000);
        send_rx1(0);
        @(negedge clk) band_en = 5'b11111;
        send_rx1(700000);
        send_rx1(0);

        // R7 strobes while busy are ignored
        tag = "R7";
        @(negedge clk) begin rx1_in = 24'(2222222); in_valid = 1'b1; end
        @(negedge clk) rx1_in = 24'(-3333333);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk) in_valid = 1'b0;
        repeat (8) @(negedge clk);

        // R6 back-to-back spacing with mixed enables
        tag = "R6";
        @(negedge clk) begin band_en = 5'b01101; src_sel = 3'd5; in_valid = 1'b1; end
        repeat (20) @(negedge clk) rx3_in = 24'(rnd(6000000));
        @(negedge clk) in_valid = 1'b0;
        repeat (8) @(negedge clk);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule